// File: doc/BRIEF.md
# Windowed-Parity 34-bit Adder

The block adds two 34-bit operands and a carry-in. Alongside the sum it delivers a predicted parity for one of two overlapping 32-bit slices of that sum. A per-operation input chooses the slice. When it is low, the slice is bits 0..31. When it is high, the slice is bits 2..33. The prediction never looks at the finished sum. It is built from operand parities and the parity of the carry into each bit, and those carries are rebuilt per group from the group carry-ins. The 30 bits that both slices share (2..31) are folded into one term. Only the two-bit edge terms are chosen by the select.

A separate checker takes the real parity of the chosen slice from the sum output. It compares that parity with the prediction and flags any mismatch. A test input can invert the carry into one chosen group, in the sum path only, so that the checker's detection can be exercised. A compile-time parameter sets the carry-group size (byte or nibble). A second parameter adds an optional output register stage of one cycle.

Top module: `win_parity_adder`

## Requirements
- R1: With the fault input off, {carry_o, sum_o} equals op_a + op_b + carry_in as a 35-bit value.
- R2: par_pred_o is 1 when the chosen slice of the fault-free sum holds an odd number of ones. win_hi = 0 chooses bits 31..0 and win_hi = 1 chooses bits 33..2.
- R3: par_act_o is the odd-count parity of the chosen slice of sum_o as it is actually output, including the effect of any forced fault.
- R4: par_err_o equals par_pred_o XOR par_act_o, and it is 0 whenever the fault input is off.
- R5: With flt_en = 1 and flt_grp = k < NG, the carry into group k (bits k*GRP upward) is inverted in the sum path only. Only that group's sum bits change, plus carry_o when k is the top group. par_pred_o is unaffected.
- R6: A flt_grp value of NG or above has no effect on any output, even with flt_en = 1.
- R7: GRP = 8 and GRP = 4 give identical outputs for identical inputs.
- R8: With REG_OUT = 1, every output appears one clock after its inputs, and all outputs read 0 while rst_n is low. With REG_OUT = 0, the outputs follow the inputs in the same cycle.
- R9: With both operands 0, carry-in 0 and group k forced, bit k*GRP of sum_o is 1. If that bit lies in the chosen slice, par_err_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| win_hi | input | 1 | Slice select: 0 = bits 31..0, 1 = bits 33..2 |
| flt_en | input | 1 | Enable forced carry inversion |
| flt_grp | input | FGW | Index of the group whose carry-in is inverted |
| sum_o | output | W | Sum |
| carry_o | output | 1 | Carry out of bit W-1 |
| par_pred_o | output | 1 | Predicted slice parity |
| par_act_o | output | 1 | Parity of the chosen slice of sum_o |
| par_err_o | output | 1 | Mismatch between predicted and actual parity |

## Verification
A wrong group carry inside the predictor shows up at once as a set par_err_o on a fault-free operation. It also shows as a par_pred_o that disagrees with the slice parity of the correct sum_o. A wrong carry in the sum path shows as a sum_o that differs from the arithmetic sum. An edge term taken from the wrong side of the shared region appears only when bits 0..1 and 32..33 have different parity, so the bench includes operands that cause this with both select values. The fault is seen in the same cycle, or one clock later with the output stage on.

// File: rtl/wpa_pkg.sv
package wpa_pkg;
  localparam int SUM_W = 34;
  localparam int WIN_W = 32;

  typedef enum logic {
    WIN_LO = 1'b0,
    WIN_HI = 1'b1
  } win_sel_e;
endpackage

// File: rtl/wpa_grp_carry.sv
module wpa_grp_carry #(
  parameter int GRP = 8,
  parameter int NG  = 5,
  localparam int PW = NG * GRP
) (
  input  logic [PW-1:0] a_p,
  input  logic [PW-1:0] b_p,
  input  logic          cin,
  output logic [NG:0]   gc
);
  logic [NG-1:0] g_grp;
  logic [NG-1:0] p_grp;

  assign gc[0] = cin;

  for (genvar k = 0; k < NG; k++) begin : g_blk
    logic gen_v;
    logic prp_v;
    always_comb begin
      gen_v = 1'b0;
      prp_v = 1'b1;
      for (int i = 0; i < GRP; i++) begin
        gen_v = (a_p[k*GRP+i] & b_p[k*GRP+i]) | ((a_p[k*GRP+i] ^ b_p[k*GRP+i]) & gen_v);
        prp_v = prp_v & (a_p[k*GRP+i] ^ b_p[k*GRP+i]);
      end
    end
    assign g_grp[k] = gen_v;
    assign p_grp[k] = prp_v;
    assign gc[k+1]  = g_grp[k] | (p_grp[k] & gc[k]);
  end
endmodule

// File: rtl/wpa_sum_path.sv
module wpa_sum_path #(
  parameter int W   = 34,
  parameter int GRP = 8,
  parameter int NG  = 5,
  parameter int FGW = 3,
  localparam int PW = NG * GRP
) (
  input  logic [PW-1:0]  a_p,
  input  logic [PW-1:0]  b_p,
  input  logic [NG:0]    gc,
  input  logic           flt_en,
  input  logic [FGW-1:0] flt_grp,
  output logic [W-1:0]   sum,
  output logic           cout
);
  logic [PW-1:0] sum_p;
  logic [PW:0]   cl;

  for (genvar k = 0; k < NG; k++) begin : g_blk
    logic [GRP:0]   lc;
    logic [GRP-1:0] s_g;
    logic           hit;
    assign hit = flt_en && (flt_grp == FGW'(k));
    always_comb begin
      lc[0] = gc[k] ^ hit;
      for (int i = 0; i < GRP; i++) begin
        s_g[i]  = a_p[k*GRP+i] ^ b_p[k*GRP+i] ^ lc[i];
        lc[i+1] = (a_p[k*GRP+i] & b_p[k*GRP+i]) | ((a_p[k*GRP+i] ^ b_p[k*GRP+i]) & lc[i]);
      end
    end
    assign sum_p[k*GRP +: GRP] = s_g;
    assign cl[k*GRP +: GRP]    = lc[GRP-1:0];
    if (k == NG - 1) begin : g_top
      assign cl[PW] = lc[GRP];
    end
  end

  assign sum  = sum_p[W-1:0];
  assign cout = cl[W];

  logic unused_sp;
  assign unused_sp = ^{sum_p, cl, gc[NG]};
endmodule

// File: rtl/wpa_predict.sv
module wpa_predict
  import wpa_pkg::*;
#(
  parameter int W   = 34,
  parameter int WIN = 32,
  parameter int GRP = 8,
  parameter int NG  = 5,
  localparam int PW = NG * GRP,
  localparam int E  = W - WIN
) (
  input  logic [PW-1:0] a_p,
  input  logic [PW-1:0] b_p,
  input  logic [NG:0]   gc,
  input  win_sel_e      sel,
  output logic          pred
);
  logic [PW:0] cp;

  for (genvar k = 0; k < NG; k++) begin : g_blk
    logic [GRP:0] lc;
    always_comb begin
      lc[0] = gc[k];
      for (int i = 0; i < GRP; i++) begin
        lc[i+1] = (a_p[k*GRP+i] & b_p[k*GRP+i]) | ((a_p[k*GRP+i] ^ b_p[k*GRP+i]) & lc[i]);
      end
    end
    assign cp[k*GRP +: GRP] = lc[GRP-1:0];
    if (k == NG - 1) begin : g_top
      assign cp[PW] = lc[GRP];
    end
  end

  logic t_shared, t_lo, t_hi;
  always_comb begin
    t_shared = (^a_p[WIN-1:E]) ^ (^b_p[WIN-1:E]) ^ (^cp[WIN-1:E]);
    t_lo     = (^a_p[E-1:0])   ^ (^b_p[E-1:0])   ^ (^cp[E-1:0]);
    t_hi     = (^a_p[W-1:WIN]) ^ (^b_p[W-1:WIN]) ^ (^cp[W-1:WIN]);
    pred     = t_shared ^ ((sel == WIN_HI) ? t_hi : t_lo);
  end

  logic unused_pr;
  assign unused_pr = ^{cp, gc[NG]};
endmodule

// File: rtl/wpa_par_check.sv
module wpa_par_check
  import wpa_pkg::*;
#(
  parameter int W   = 34,
  parameter int WIN = 32,
  localparam int E  = W - WIN
) (
  input  logic [W-1:0] sum,
  input  win_sel_e     sel,
  input  logic         pred,
  output logic         act,
  output logic         err
);
  always_comb begin
    act = (sel == WIN_HI) ? ^sum[W-1:E] : ^sum[WIN-1:0];
    err = act ^ pred;
  end
endmodule

// File: rtl/win_parity_adder.sv
module win_parity_adder
  import wpa_pkg::*;
#(
  parameter int W       = SUM_W,
  parameter int WIN     = WIN_W,
  parameter int GRP     = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int NG     = (W + GRP - 1) / GRP,
  localparam int PW     = NG * GRP,
  localparam int E      = W - WIN,
  localparam int FGW    = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           carry_in,
  input  logic           win_hi,
  input  logic           flt_en,
  input  logic [FGW-1:0] flt_grp,
  output logic [W-1:0]   sum_o,
  output logic           carry_o,
  output logic           par_pred_o,
  output logic           par_act_o,
  output logic           par_err_o
);
  logic [PW-1:0] a_p, b_p;
  logic [NG:0]   gc;
  win_sel_e      sel;
  logic [W-1:0]  sum_c;
  logic          cout_c, pred_c, act_c, err_c;

  assign a_p = PW'(op_a);
  assign b_p = PW'(op_b);
  assign sel = win_sel_e'(win_hi);

  wpa_grp_carry #(.GRP(GRP), .NG(NG)) u_gc (
    .a_p(a_p), .b_p(b_p), .cin(carry_in), .gc(gc)
  );

  wpa_sum_path #(.W(W), .GRP(GRP), .NG(NG), .FGW(FGW)) u_sum (
    .a_p(a_p), .b_p(b_p), .gc(gc), .flt_en(flt_en), .flt_grp(flt_grp),
    .sum(sum_c), .cout(cout_c)
  );

  wpa_predict #(.W(W), .WIN(WIN), .GRP(GRP), .NG(NG)) u_pred (
    .a_p(a_p), .b_p(b_p), .gc(gc), .sel(sel), .pred(pred_c)
  );

  wpa_par_check #(.W(W), .WIN(WIN)) u_chk (
    .sum(sum_c), .sel(sel), .pred(pred_c), .act(act_c), .err(err_c)
  );

  // Aligned copies of the inputs, used only by the assertions below
  logic [W-1:0]   ref_a, ref_b;
  logic           ref_c, ref_sel, ref_fen;
  logic [FGW-1:0] ref_fgrp;

  if (REG_OUT) begin : g_reg
    logic [W-1:0] sum_q, sum_d;
    logic         cout_q, pred_q, act_q, err_q;
    logic         cout_d, pred_d, act_d, err_d;
    logic         stage_en;

    assign stage_en = 1'b1;

    always_comb begin
      sum_d  = sum_q;
      cout_d = cout_q;
      pred_d = pred_q;
      act_d  = act_q;
      err_d  = err_q;
      if (stage_en) begin
        sum_d  = sum_c;
        cout_d = cout_c;
        pred_d = pred_c;
        act_d  = act_c;
        err_d  = err_c;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q  <= '0;
        cout_q <= 1'b0;
        pred_q <= 1'b0;
        act_q  <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        sum_q  <= sum_d;
        cout_q <= cout_d;
        pred_q <= pred_d;
        act_q  <= act_d;
        err_q  <= err_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_a    <= '0;
        ref_b    <= '0;
        ref_c    <= 1'b0;
        ref_sel  <= 1'b0;
        ref_fen  <= 1'b0;
        ref_fgrp <= '0;
      end else begin
        ref_a    <= op_a;
        ref_b    <= op_b;
        ref_c    <= carry_in;
        ref_sel  <= win_hi;
        ref_fen  <= flt_en;
        ref_fgrp <= flt_grp;
      end
    end

    assign sum_o      = sum_q;
    assign carry_o    = cout_q;
    assign par_pred_o = pred_q;
    assign par_act_o  = act_q;
    assign par_err_o  = err_q;
  end else begin : g_comb
    assign sum_o      = sum_c;
    assign carry_o    = cout_c;
    assign par_pred_o = pred_c;
    assign par_act_o  = act_c;
    assign par_err_o  = err_c;
    assign ref_a      = op_a;
    assign ref_b      = op_b;
    assign ref_c      = carry_in;
    assign ref_sel    = win_hi;
    assign ref_fen    = flt_en;
    assign ref_fgrp   = flt_grp;
  end

  logic [W:0] ref_total;
  logic       ref_fault;
  assign ref_total = {1'b0, ref_a} + {1'b0, ref_b} + (W+1)'(ref_c);
  assign ref_fault = ref_fen && (int'(ref_fgrp) < NG);

  assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_fen |-> ({carry_o, sum_o} == ref_total));

  assert_pred_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_fen |-> (par_pred_o == (ref_sel ? ^sum_o[W-1:E] : ^sum_o[WIN-1:0])));

  assert_no_err_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_fen |-> !par_err_o);

  assert_fault_changes_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fault |-> ({carry_o, sum_o} != ref_total));

  assert_idx_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_fen && !ref_fault) |-> (({carry_o, sum_o} == ref_total) && !par_err_o));
endmodule

// File: tb/win_parity_adder_test.sv
module win_parity_adder_test;
  localparam int W = 34;

  typedef struct {
    logic [W-1:0] s;
    logic         co, pr, ac, er;
    int           due;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a, b;
  logic         cin, sel, fen;
  logic [3:0]   fg;

  logic [W-1:0] s8, s4;
  logic         co8, pr8, ac8, er8, co4, pr4, ac4, er4;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  exp_t q8[$];
  exp_t q4[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  win_parity_adder #(.GRP(8), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .carry_in(cin), .win_hi(sel),
    .flt_en(fen), .flt_grp(fg[2:0]), .sum_o(s8), .carry_o(co8),
    .par_pred_o(pr8), .par_act_o(ac8), .par_err_o(er8)
  );

  win_parity_adder #(.GRP(4), .REG_OUT(1'b0)) uut_nib (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .carry_in(cin), .win_hi(sel),
    .flt_en(fen), .flt_grp(fg), .sum_o(s4), .carry_o(co4),
    .par_pred_o(pr4), .par_act_o(ac4), .par_err_o(er4)
  );

  function automatic logic win_par(logic [W-1:0] v, logic hi);
    return hi ? ^v[W-1:2] : ^v[31:0];
  endfunction

  function automatic exp_t model(logic [W-1:0] ia, logic [W-1:0] ib, logic ic,
                                 logic hi, logic f_on, int f_idx, int grp);
    exp_t e;
    logic [63:0] full, lowm, m, gv;
    logic [W-1:0] sf;
    logic cof, cg;
    int ng, lo, wd;
    full = 64'(ia) + 64'(ib) + 64'(ic);
    sf   = full[W-1:0];
    cof  = full[W];
    ng   = (W + grp - 1) / grp;
    if (f_on && f_idx < ng) begin
      lo   = f_idx * grp;
      wd   = (W - lo < grp) ? (W - lo) : grp;
      lowm = (64'd1 << lo) - 64'd1;
      cg   = ((((64'(ia) & lowm) + (64'(ib) & lowm) + 64'(ic)) >> lo) & 64'd1) != 0;
      m    = (64'd1 << wd) - 64'd1;
      gv   = ((64'(ia) >> lo) & m) + ((64'(ib) >> lo) & m) + 64'(!cg);
      for (int i = 0; i < wd; i++) sf[lo+i] = gv[i];
      if (lo + wd == W) cof = gv[wd];
    end
    e.s  = sf;
    e.co = cof;
    e.pr = win_par(full[W-1:0], hi);
    e.ac = win_par(sf, hi);
    e.er = e.pr ^ e.ac;
    return e;
  endfunction

  task automatic drive(logic [W-1:0] ia, logic [W-1:0] ib, logic ic, logic hi,
                       logic f_on, logic [3:0] f_idx, string req);
    exp_t e8, e4;
    @(posedge clk);
    #1;
    a = ia; b = ib; cin = ic; sel = hi; fen = f_on; fg = f_idx;
    e8 = model(ia, ib, ic, hi, f_on, int'(f_idx[2:0]), 8);
    e8.due = cyc + 1;
    e8.req = req;
    e4 = model(ia, ib, ic, hi, f_on, int'(f_idx), 4);
    e4.due = cyc;
    e4.req = {req, " R7"};
    q8.push_back(e8);
    q4.push_back(e4);
  endtask

  task automatic compare(string who, exp_t e, logic [W-1:0] s, logic co,
                         logic pr, logic ac, logic er);
    n_chk++;
    if (s !== e.s || co !== e.co || pr !== e.pr || ac !== e.ac || er !== e.er) begin
      n_bad++;
      $display("FAIL %s %s: got sum=%h co=%b pred=%b act=%b err=%b exp sum=%h co=%b pred=%b act=%b err=%b",
               who, e.req, s, co, pr, ac, er, e.s, e.co, e.pr, e.ac, e.er);
    end
  endtask

  // Monitor: pops expected items when each instance's result is due
  initial begin
    forever begin
      @(posedge clk);
      #6;
      while (q8.size() > 0 && q8[0].due == cyc) begin
        exp_t e;
        e = q8.pop_front();
        compare("byte/reg", e, s8, co8, pr8, ac8, er8);
      end
      while (q4.size() > 0 && q4[0].due == cyc) begin
        exp_t e;
        e = q4.pop_front();
        compare("nibble/comb", e, s4, co4, pr4, ac4, er4);
      end
    end
  end

  initial begin
    #2000000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; cin = 1'b0; sel = 1'b0; fen = 1'b0; fg = '0;
    a = 34'h3_FFFF_FFFF;
    b = 34'h1;
    repeat (3) @(posedge clk);
    #3;
    // R8: registered outputs held clear during reset
    n_chk++;
    if ({s8, co8, pr8, ac8, er8} !== '0) begin
      n_bad++;
      $display("FAIL R8 reset: got %h expected 0", {s8, co8, pr8, ac8, er8});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R4 corner operands, both windows
    for (int h = 0; h < 2; h++) begin
      drive('0, '0, 1'b0, h[0], 1'b0, 4'd0, "R1 R2 R4 zeros");
      drive(34'h3_FFFF_FFFF, 34'h3_FFFF_FFFF, 1'b1, h[0], 1'b0, 4'd0, "R1 R2 R4 all ones");
      drive(34'h2_AAAA_AAAA, 34'h1_5555_5555, 1'b1, h[0], 1'b0, 4'd0, "R1 R2 R4 alternating full carry");
      drive(34'h2_AAAA_AAAA, 34'h2_AAAA_AAAA, 1'b0, h[0], 1'b0, 4'd0, "R1 R2 R4 alternating");
      drive(34'h3_FFFF_FFFF, '0, 1'b1, h[0], 1'b0, 4'd0, "R1 R2 R4 carry-in ripple");
      drive(34'h0_0000_0001, '0, 1'b0, h[0], 1'b0, 4'd0, "R2 edge bit 0 only");
      drive(34'h2_0000_0000, '0, 1'b0, h[0], 1'b0, 4'd0, "R2 edge bit 33 only");
    end

    // R9: single forced carry on zero operands, every index
    for (int k = 0; k < 9; k++) begin
      drive('0, '0, 1'b0, 1'b0, 1'b1, 4'(k), "R9 R5 forced carry lo window");
      drive('0, '0, 1'b0, 1'b1, 1'b1, 4'(k), "R9 R5 forced carry hi window");
    end

    // R6: out-of-range group index (>=9 for nibble, 5..7 for byte)
    for (int k = 9; k < 16; k++) begin
      drive(34'h1_2345_6789, 34'h2_FEDC_BA98, 1'b1, k[0], 1'b1, 4'(k), "R6 index out of range");
    end
    drive(34'h3_0F0F_0F0F, 34'h0_F0F0_F0F1, 1'b0, 1'b1, 1'b1, 4'd6, "R6 byte index out of range");

    // R1 R2 R3 R4 R5 random operands, with and without faults
    for (int n = 0; n < 600; n++) begin
      logic [W-1:0] ra, rb;
      logic [3:0] rk;
      logic rf;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      rk = 4'($urandom_range(0, 15));
      rf = (n % 3 == 0);
      drive(ra, rb, 1'($urandom()), 1'($urandom()), rf, rk, rf ? "R3 R5 random fault" : "R1 R2 R4 random");
    end

    drive('0, '0, 1'b0, 1'b0, 1'b0, 4'd0, "R8 drain");
    repeat (4) @(posedge clk);
    #8;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule